// File: doc/BRIEF.md
# 64b/66b Block Encoder with Payload Scrambler

This block turns one 64-bit parallel word, with an 8-bit mask that marks which bytes are control characters, into a 66-bit line block on every clock. A block is a 2-bit sync header and a 64-bit payload. A word made only of data is copied into the payload. A word that holds any control character is repacked. The first payload byte becomes a block type, control characters shrink to 7-bit codes, and ordered sets carry a 4-bit code. The payload then goes through a self-synchronous scrambler. The header is never scrambled.

Byte lane 0 is `txd[7:0]` and lane j is `txd[8j+7:8j]`. Bit j of `txc` set means lane j is a control character. In the payload, bit 0 is the first bit sent. The type field is `payload[7:0]`. The 7-bit code that belongs to control lane j always sits at `payload[8+7j +: 7]`. Recognised control characters are idle 0x07, start 0xFB, terminate 0xFD, error 0xFE, sequence 0x9C and signal 0x5C. Idle becomes code 0x00 and error becomes code 0x1E.

Top module: `enc66_encoder`

## Requirements
- R1: When `txc` is 0x00, the header is 2'b10. With the scrambler bypassed, the payload equals `txd` bit for bit.
- R2: When `txc` is nonzero, the header is 2'b01 and `payload[7:0]` holds a block type. The header values 2'b00 and 2'b11 never appear after reset.
- R3: When every lane is control and each lane is idle (0x07) or error (0xFE), the type is 0x1E. The code of lane j (idle 0x00, error 0x1E) is placed at bit 8+7j.
- R4: When `txc` is 0x01 and lane 0 is 0xFB, the type is 0x78 and lanes 1 to 7 fill `payload[63:8]` unchanged.
- R5: A terminate in lane k requires all of the following:
  - `txc` equals 0xFF shifted left by k;
  - lane k is 0xFD;
  - every later lane is idle or error.
  The type is 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0 to 7. Data lanes 0 to k-1 fill bits 8 up to 8+8k-1. Then come 7-k zero pad bits, then the codes of lanes k+1 to 7 at bit 8+7j.
- R6: When `txc` is 0xF1, lane 0 is 0x9C or 0x5C, and lanes 4 to 7 are idle or error, the type is 0x4B. Lanes 1 to 3 go to `payload[31:8]`. `payload[35:32]` holds the O code, 0x0 for 0x9C and 0xF for 0x5C. The codes of lanes 4 to 7 sit at bit 8+7j.
- R7: Any other control pattern gives an error block. Its type is 0x1E and all eight lane codes are 0x1E, so the raw payload is 64'h3C78F1E3C78F1E1E.
- R8: With `scr_bypass` low, output bit i is the raw bit XOR the scrambled bit sent 39 bits earlier XOR the one sent 58 bits earlier. Bits are counted serially, bit 0 first, and the count runs on across words. Reset loads all 58 history bits with ones. The header is never scrambled.
- R9: With `scr_bypass` high, the raw payload is output. The scrambler history still advances on that word.
- R10: The output follows the input after exactly one rising edge and holds until the next edge. While `rst` is high, the header is 2'b01 and the payload is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd | input | 64 | Eight byte lanes, lane 0 in the low byte |
| txc | input | 8 | Per-lane control flag |
| scr_bypass | input | 1 | High sends the raw payload |
| blk_hdr | output | 2 | Sync header, registered |
| blk_payload | output | 64 | Block payload, registered |

## Verification
The scrambler history is the only state that spans cycles. If it goes wrong, the very next scrambled payload differs from the serial model, and the error never clears. Each output word feeds back into the history, so a single bad bit keeps reappearing 39 and 58 bit-times later in every following word. Packing faults are stateless and appear in the block produced one edge after the bad input. With bypass on, they can be read directly as a wrong type, a wrong code position or a wrong pad. A priority fault between layouts appears as a valid-looking block with the wrong type rather than as the error block.

// File: rtl/enc66_pkg.sv
package enc66_pkg;
  localparam int LANES   = 8;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 7;
  localparam int OCODE_W = 4;
  localparam int TYPE_W  = 8;
  localparam int HDR_W   = 2;
  localparam int WORD_W  = LANES * BYTE_W;

  localparam logic [HDR_W-1:0] HDR_DATA = 2'b10;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b01;

  localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;
  localparam logic [BYTE_W-1:0] CH_SEQ   = 8'h9C;
  localparam logic [BYTE_W-1:0] CH_SIG   = 8'h5C;

  localparam logic [CODE_W-1:0] C7_IDLE = 7'h00;
  localparam logic [CODE_W-1:0] C7_ERR  = 7'h1E;

  localparam logic [TYPE_W-1:0] TY_CTRL  = 8'h1E;
  localparam logic [TYPE_W-1:0] TY_START = 8'h78;
  localparam logic [TYPE_W-1:0] TY_OSET  = 8'h4B;

  localparam logic [LANES-1:0] MASK_START = 8'h01;
  localparam logic [LANES-1:0] MASK_OSET  = 8'hF1;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } code7_t;

  typedef enum logic [2:0] {
    K_DATA, K_IDLE, K_START, K_OSET, K_TERM, K_ERROR
  } kind_t;

  function automatic code7_t squeeze(input logic [BYTE_W-1:0] ch);
    code7_t r;
    case (ch)
      CH_IDLE: r = '{ok: 1'b1, code: C7_IDLE};
      CH_ERR:  r = '{ok: 1'b1, code: C7_ERR};
      default: r = '{ok: 1'b0, code: C7_ERR};
    endcase
    return r;
  endfunction

  function automatic logic [TYPE_W-1:0] term_type(input int k);
    case (k)
      0:       return 8'h87;
      1:       return 8'h99;
      2:       return 8'hAA;
      3:       return 8'hB4;
      4:       return 8'hCC;
      5:       return 8'hD2;
      6:       return 8'hE1;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [OCODE_W-1:0] ocode_of(input logic [BYTE_W-1:0] ch);
    return (ch == CH_SIG) ? 4'hF : 4'h0;
  endfunction
endpackage

// File: rtl/enc66_lane_codes.sv
module enc66_lane_codes
  import enc66_pkg::*;
(
  input  logic [WORD_W-1:0]             txd,
  input  logic [LANES-1:0]              txc,
  output logic [LANES-1:0][CODE_W-1:0]  codes,
  output logic [LANES-1:0]              code_ok
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    code7_t c;
    assign c          = squeeze(txd[BYTE_W*l +: BYTE_W]);
    assign codes[l]   = c.code;
    assign code_ok[l] = txc[l] & c.ok;
  end
endmodule

// File: rtl/enc66_packer.sv
module enc66_packer
  import enc66_pkg::*;
(
  input  logic [WORD_W-1:0]             txd,
  input  logic [LANES-1:0]              txc,
  input  logic [LANES-1:0][CODE_W-1:0]  codes,
  input  logic [LANES-1:0]              code_ok,
  output logic [HDR_W-1:0]              hdr,
  output logic [WORD_W-1:0]             raw
);
  localparam int CODE_BASE = TYPE_W;
  localparam int OS_DATA_LANES = 3;
  localparam int OS_OCODE_POS = TYPE_W + OS_DATA_LANES * BYTE_W;
  localparam int OS_CTRL_FIRST = OS_DATA_LANES + 1;

  logic [LANES-1:0][WORD_W-1:0] term_pay;
  logic [LANES-1:0]             term_match;
  logic [WORD_W-1:0]            idle_word, err_word, start_word, oset_word, term_word;
  logic                         term_hit, oset_ok;
  kind_t                        kind;

  // One candidate block per terminate position
  for (genvar k = 0; k < LANES; k++) begin : g_term
    localparam logic [LANES-1:0] TXC_M = {LANES{1'b1}} << k;
    localparam logic [LANES-1:0] AFTER = TXC_M << 1;
    logic [WORD_W-1:0] tp;
    always_comb begin
      tp = '0;
      tp[TYPE_W-1:0] = term_type(k);
      for (int b = 0; b < k; b++)
        tp[TYPE_W + BYTE_W*b +: BYTE_W] = txd[BYTE_W*b +: BYTE_W];
      for (int j = k + 1; j < LANES; j++)
        tp[CODE_BASE + CODE_W*j +: CODE_W] = codes[j];
    end
    assign term_pay[k]   = tp;
    assign term_match[k] = (txc == TXC_M) &&
                           (txd[BYTE_W*k +: BYTE_W] == CH_TERM) &&
                           ((code_ok | ~AFTER) == {LANES{1'b1}});
  end

  always_comb begin
    term_hit  = 1'b0;
    term_word = '0;
    for (int k = 0; k < LANES; k++) begin
      if (term_match[k]) begin
        term_hit  = 1'b1;
        term_word = term_pay[k];
      end
    end
  end

  always_comb begin
    idle_word = '0;
    err_word  = '0;
    idle_word[TYPE_W-1:0] = TY_CTRL;
    err_word[TYPE_W-1:0]  = TY_CTRL;
    for (int j = 0; j < LANES; j++) begin
      idle_word[CODE_BASE + CODE_W*j +: CODE_W] = codes[j];
      err_word[CODE_BASE + CODE_W*j +: CODE_W]  = C7_ERR;
    end
  end

  assign start_word = {txd[WORD_W-1:BYTE_W], TY_START};

  always_comb begin
    oset_word = '0;
    oset_word[TYPE_W-1:0] = TY_OSET;
    oset_word[TYPE_W +: OS_DATA_LANES*BYTE_W] = txd[BYTE_W +: OS_DATA_LANES*BYTE_W];
    oset_word[OS_OCODE_POS +: OCODE_W] = ocode_of(txd[BYTE_W-1:0]);
    for (int j = OS_CTRL_FIRST; j < LANES; j++)
      oset_word[CODE_BASE + CODE_W*j +: CODE_W] = codes[j];
  end

  assign oset_ok = (txc == MASK_OSET) &&
                   ((txd[BYTE_W-1:0] == CH_SEQ) || (txd[BYTE_W-1:0] == CH_SIG)) &&
                   (&code_ok[LANES-1:OS_CTRL_FIRST]);

  // Layout priority: data, all-control, start, ordered set, terminate, error
  always_comb begin
    if (txc == '0)                                  kind = K_DATA;
    else if (&code_ok)                              kind = K_IDLE;
    else if ((txc == MASK_START) &&
             (txd[BYTE_W-1:0] == CH_START))         kind = K_START;
    else if (oset_ok)                               kind = K_OSET;
    else if (term_hit)                              kind = K_TERM;
    else                                            kind = K_ERROR;
  end

  always_comb begin
    hdr = (kind == K_DATA) ? HDR_DATA : HDR_CTRL;
    case (kind)
      K_DATA:  raw = txd;
      K_IDLE:  raw = idle_word;
      K_START: raw = start_word;
      K_OSET:  raw = oset_word;
      K_TERM:  raw = term_word;
      default: raw = err_word;
    endcase
  end
endmodule

// File: rtl/enc66_scrambler.sv
module enc66_scrambler #(
  parameter int          W      = 64,
  parameter int          ST     = 58,
  parameter int          TAP    = 39,
  parameter logic [57:0] SEED   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int EXT_W = ST + W;

  logic [ST-1:0]    state;
  logic [EXT_W-1:0] ext;

  // ext[0] is the oldest history bit; ext[ST+i] is output bit i
  always_comb begin
    ext = '0;
    ext[ST-1:0] = state;
    for (int i = 0; i < W; i++)
      ext[ST+i] = din[i] ^ ext[ST+i-TAP] ^ ext[i];
  end

  assign dout = ext[EXT_W-1:ST];

  always_ff @(posedge clk) begin
    if (rst) state <= SEED[ST-1:0];
    else     state <= ext[EXT_W-1:W];
  end
endmodule

// File: rtl/enc66_encoder.sv
module enc66_encoder
  import enc66_pkg::*;
#(
  parameter logic [57:0] SCR_SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       txd,
  input  logic [7:0]        txc,
  input  logic              scr_bypass,
  output logic [1:0]        blk_hdr,
  output logic [63:0]       blk_payload
);
  logic [LANES-1:0][CODE_W-1:0] codes;
  logic [LANES-1:0]             code_ok;
  logic [HDR_W-1:0]             hdr_c;
  logic [WORD_W-1:0]            raw_c, scr_c;

  enc66_lane_codes codes_i (
    .txd     (txd),
    .txc     (txc),
    .codes   (codes),
    .code_ok (code_ok)
  );

  enc66_packer pack_i (
    .txd     (txd),
    .txc     (txc),
    .codes   (codes),
    .code_ok (code_ok),
    .hdr     (hdr_c),
    .raw     (raw_c)
  );

  enc66_scrambler #(
    .W    (WORD_W),
    .ST   (58),
    .TAP  (39),
    .SEED (SCR_SEED)
  ) scr_i (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_c),
    .dout (scr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_hdr     <= HDR_CTRL;
      blk_payload <= '0;
    end else begin
      blk_hdr     <= hdr_c;
      blk_payload <= scr_bypass ? raw_c : scr_c;
    end
  end
endmodule

// File: rtl/enc66_checker.sv
module enc66_checker (
  input logic        clk,
  input logic        rst,
  input logic [63:0] txd,
  input logic [7:0]  txc,
  input logic        scr_bypass,
  input logic [1:0]  blk_hdr,
  input logic [63:0] blk_payload
);
  AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (blk_hdr != 2'b00) && (blk_hdr != 2'b11)); // R2

  AST_DATA_HDR: assert property (@(posedge clk) disable iff (rst)
    (txc == 8'h00) |=> (blk_hdr == 2'b10)); // R1

  AST_CTRL_HDR: assert property (@(posedge clk) disable iff (rst)
    (txc != 8'h00) |=> (blk_hdr == 2'b01)); // R2

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    (scr_bypass && txc == 8'h00) |=> (blk_payload == $past(txd))); // R1

  AST_START_FIELD: assert property (@(posedge clk) disable iff (rst)
    (scr_bypass && txc == 8'h01 && txd[7:0] == 8'hFB)
      |=> (blk_payload == {$past(txd[63:8]), 8'h78})); // R4

  AST_OSET_FIELD: assert property (@(posedge clk) disable iff (rst)
    (scr_bypass && txc == 8'hF1 && txd[7:0] == 8'h9C && txd[63:32] == 32'h07070707)
      |=> (blk_payload[7:0] == 8'h4B && blk_payload[35:32] == 4'h0)); // R6

  AST_RESET_VAL: assert property (@(posedge clk)
    rst |=> (blk_hdr == 2'b01 && blk_payload == 64'h0)); // R10
endmodule

bind enc66_encoder enc66_checker chk_i (.*);

// File: tb/enc66_encoder_tb_top.sv
module enc66_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] txd = '0;
  logic [7:0]  txc = '0;
  logic        scr_bypass = 1'b1;
  logic [1:0]  blk_hdr;
  logic [63:0] blk_payload;

  always #5 clk = ~clk;

  enc66_encoder dut_i (
    .clk (clk), .rst (rst), .txd (txd), .txc (txc),
    .scr_bypass (scr_bypass), .blk_hdr (blk_hdr), .blk_payload (blk_payload)
  );

  localparam logic [63:0] EBLK = 64'h3C78F1E3C78F1E1E;
  localparam int NV = 14;
  // R1 data, R3 idle/err codes, R7 bad chars, R4 start, R5 terminates, R6 ordered sets
  localparam logic [63:0] V_D [NV] = '{
    64'h0123456789ABCDEF, 64'h0707070707070707, 64'h0707070707FE0707,
    64'h070707079C070707, 64'hD5555555555555FB, 64'h07070707070707FD,
    64'h0707FE07FDAABBCC, 64'hFD11223344556677, 64'h070707071122339C,
    64'h070707071122335C, 64'h0000000000000700, 64'h0000000000000007,
    64'h0000000000FD0000, 64'h0707FD1122334455 };
  localparam logic [7:0] V_C [NV] = '{
    8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 8'hF8,
    8'h80, 8'hF1, 8'hF1, 8'h02, 8'h01, 8'h04, 8'hE0 };
  localparam logic [1:0] V_H [NV] = '{
    2'b10, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01 };
  localparam logic [63:0] V_P [NV] = '{
    64'h0123456789ABCDEF, 64'h000000000000001E, 64'h000000000780001E,
    EBLK,                 64'hD555555555555578, 64'h0000000000000087,
    64'h0000F000AABBCCB4, 64'h11223344556677FF, 64'h000000001122334B,
    64'h0000000F1122334B, EBLK,                 EBLK,
    EBLK,                 64'h00001122334455D2 };
  localparam int V_R [NV] = '{1, 3, 3, 7, 4, 5, 5, 5, 6, 6, 7, 7, 7, 5};

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [57:0] hist;

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, one rising edge later
  task automatic drive(input logic [63:0] d, input logic [7:0] c, input logic b);
    txd = d; txc = c; scr_bypass = b;
    @(negedge clk);
  endtask

  // Serial model: hist[0] is the most recent scrambled bit
  task automatic scr_step(input logic [63:0] d, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      s[i] = d[i] ^ hist[38] ^ hist[57];
      hist = {hist[56:0], s[i]};
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist = '1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_s;
    logic [63:0] dummy;
    // R10: reset values with live data on the inputs
    txd = 64'hFFFF_FFFF_FFFF_FFFF; txc = 8'h00; scr_bypass = 1'b0;
    @(negedge clk); @(negedge clk);
    cmp("R10 reset hdr", {62'b0, blk_hdr}, 64'h1);
    cmp("R10 reset payload", blk_payload, 64'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(V_D[v], V_C[v], 1'b1);
      cmp($sformatf("R%0d vec%0d hdr", V_R[v], v), {62'b0, blk_hdr}, {62'b0, V_H[v]});
      cmp($sformatf("R%0d vec%0d payload", V_R[v], v), blk_payload, V_P[v]);
      if (blk_hdr == 2'b00 || blk_hdr == 2'b11)
        cmp("R2 illegal header", {62'b0, blk_hdr}, 64'h1);
    end

    // R10: output holds until the next edge, then follows
    drive(64'hAAAA_5555_AAAA_5555, 8'h00, 1'b1);
    txd = 64'h1234_5678_9ABC_DEF0;
    #1;
    cmp("R10 hold before edge", blk_payload, 64'hAAAA_5555_AAAA_5555);
    @(negedge clk);
    cmp("R10 follow after edge", blk_payload, 64'h1234_5678_9ABC_DEF0);

    // R8: scrambled payload against the serial model, from the reset seed
    do_reset();
    scr_step(64'h0, exp_s);
    drive(64'h0, 8'h00, 1'b0);
    cmp("R8 zero word", blk_payload, exp_s);
    scr_step(64'hFFFF_FFFF_FFFF_FFFF, exp_s);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1'b0);
    cmp("R8 ones word", blk_payload, exp_s);
    scr_step(64'h0123_4567_89AB_CDEF, exp_s);
    drive(64'h0123_4567_89AB_CDEF, 8'h00, 1'b0);
    cmp("R8 mixed word", blk_payload, exp_s);
    scr_step(64'h1E, exp_s);
    drive(64'h0707_0707_0707_0707, 8'hFF, 1'b0);
    cmp("R8 header not scrambled", {62'b0, blk_hdr}, 64'h1);
    cmp("R8 idle block scrambled", blk_payload, exp_s);

    // R9: bypassed word is raw but still advances the history
    do_reset();
    scr_step(64'hDEAD_BEEF_0000_FFFF, dummy);
    drive(64'hDEAD_BEEF_0000_FFFF, 8'h00, 1'b1);
    cmp("R9 bypass raw", blk_payload, 64'hDEAD_BEEF_0000_FFFF);
    scr_step(64'h0, exp_s);
    drive(64'h0, 8'h00, 1'b0);
    cmp("R9 history advanced under bypass", blk_payload, exp_s);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule